// File: doc/BRIEF.md
# Comparative Self-Test Tile

This block checks two identically configured lookup-table blocks against each other instead of against stored golden answers. A pulse on `start` clears the tile and launches a test run. A binary counter then walks every one of the 2^N input vectors. Each vector goes to both blocks in the same cycle, and one comparator looks at their outputs. A single disagreement on any vector sets a fail flag, and the flag stays set until the next `start`. When the last vector has been compared, `done` rises and the fail flag becomes meaningful.

The result bit is also loaded into a one-stage scan cell clocked by a separate test clock. Several tiles can chain their cells and shift their verdicts out serially. There are two proving aids. A self-check input turns the second block into the complement of the first, so a correct tile must report fail; this shows that the result path is not stuck at pass. A fault-injection input flips one output bit of the second block at one chosen vector.

The blocks under test are behavioural models whose truth tables come from a parameter. The number of compared outputs is a parameter because it depends on the mode being tested. All control and status pins are plain levels; the block has no streaming data interface.

Top module: `selftest_tile`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `scan_out` are all 0.
- R2: A `start` sampled high on a `clk` edge makes `busy` 1, `done` 0 and `fail` 0 after that edge, whatever the earlier state.
- R3: A run compares all 2^N vectors, one per cycle starting with vector 0. `busy` stays high for exactly 2^N cycles after the start edge, and then `done` rises together with the fall of `busy`.
- R4: With self-check and fault injection both low, a run ends with `done`=1 and `fail`=0.
- R5: With `fault_en`=1, the second block's output bit `fault_bit` is inverted on vector `fault_pat` only. Such a run ends with `fail`=1 for any vector from 0 to 2^N-1 and any output bit.
- R6: Once set, `fail` stays 1 until the next `start`, even if the cause is removed and `clk` keeps running.
- R7: With `selfcheck`=1 the second block outputs the complement of the first, and the run ends with `fail`=1.
- R8: On a rising `tck` edge with `scan_en`=0, the scan cell captures `fail`. With `scan_en`=1 it loads `scan_in`. `scan_out` always shows the cell.
- R9: A `start` during a run restarts it from vector 0. The run again lasts exactly 2^N cycles from the new start edge.
- R10: `busy` and `done` are never both 1. `done` holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for generator and comparator |
| rst_n | input | 1 | Asynchronous active-low reset for the whole tile |
| start | input | 1 | Clears the tile and begins a run |
| selfcheck | input | 1 | Makes the second block the complement of the first |
| fault_en | input | 1 | Enables the single-bit fault in the second block |
| fault_pat | input | N | Vector at which the fault is applied |
| fault_bit | input | BW | Output bit that the fault inverts |
| tck | input | 1 | Test clock for the scan cell |
| scan_en | input | 1 | 1: shift from `scan_in`; 0: capture `fail` |
| scan_in | input | 1 | Serial input from the previous tile |
| scan_out | output | 1 | Serial output, the scan cell |
| busy | output | 1 | A run is in progress |
| done | output | 1 | All vectors compared; `fail` is valid |
| fail | output | 1 | Latched mismatch flag |

## Verification
A counter that skips or repeats a vector shows up as a `busy` window that differs from 2^N cycles. This appears on the very run in which it happens. A comparator that misses a mismatch, forgets one, or never clears shows a wrong `fail` when `done` rises. The bench probes this with faults on the first and last vectors, on both output bits, in self-check mode, and across a restart, so each mistake is visible within one run. A wrong scan cell shows a wrong `scan_out` one `tck` edge after capture or shift.

// File: rtl/tile_pkg.sv
package tile_pkg;
  typedef enum logic [1:0] {
    GEN_IDLE = 2'd0,
    GEN_RUN  = 2'd1,
    GEN_DONE = 2'd2
  } gen_state_t;
endpackage

// File: rtl/tile_pattern_gen.sv
module tile_pattern_gen #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic [N-1:0] pattern,
  output logic         compare_en,
  output logic         busy,
  output logic         done
);
  import tile_pkg::*;
  localparam logic [N-1:0] LAST = {N{1'b1}};

  gen_state_t   state_q;
  logic [N-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      state_q <= GEN_RUN;
      cnt_q   <= '0;
    end else if (state_q == GEN_RUN) begin
      if (cnt_q == LAST) begin
        state_q <= GEN_DONE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pattern    = cnt_q;
  assign compare_en = (state_q == GEN_RUN);
  assign busy       = (state_q == GEN_RUN);
  assign done       = (state_q == GEN_DONE);

  // R3: vectors advance by one each cycle of a run
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && cnt_q != LAST) |=> (busy && cnt_q == N'($past(cnt_q) + 1'b1)));
  // R3: the last vector ends the run
  assert_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && cnt_q == LAST) |=> (done && !busy));
  // R9: a start always begins at vector zero
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cnt_q == '0));
  // R10: done holds until start
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/tile_lut_model.sv
module tile_lut_model #(
  parameter int N     = 4,
  parameter int OUT_W = 2,
  parameter int BW    = 1,
  parameter logic [OUT_W*(2**N)-1:0] TABLE = '0
) (
  input  logic [N-1:0]     addr,
  input  logic             invert,
  input  logic             flip_en,
  input  logic [N-1:0]     flip_pat,
  input  logic [BW-1:0]    flip_bit,
  output logic [OUT_W-1:0] y
);
  localparam int DEPTH = 2 ** N;

  for (genvar o = 0; o < OUT_W; o++) begin : g_out
    logic hit;
    assign hit  = flip_en && (flip_pat == addr) && (flip_bit == BW'(o));
    assign y[o] = TABLE[o*DEPTH + int'(addr)] ^ invert ^ hit;
  end
endmodule

// File: rtl/tile_comparator.sv
module tile_comparator #(
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [OUT_W-1:0] resp_a,
  input  logic [OUT_W-1:0] resp_b,
  output logic             fail
);
  logic mismatch;
  assign mismatch = en && (resp_a != resp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail <= 1'b0;
    else if (clear)    fail <= 1'b0;
    else if (mismatch) fail <= 1'b1;
  end

  // R2: start clears the flag
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !fail);
  // R5: a compared mismatch is latched
  assert_catch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clear && resp_a != resp_b) |=> fail);
  // R6: the flag is sticky until the next clear
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> fail);
endmodule

// File: rtl/tile_scan_cell.sv
module tile_scan_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic scan_en,
  input  logic scan_in,
  input  logic capture_d,
  output logic q
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (scan_en) q <= scan_in;
    else              q <= capture_d;
  end

  // R8: shift mode loads the serial input
  assert_shift_R8: assert property (@(posedge tck) disable iff (!rst_n)
    scan_en |=> (q == $past(scan_in)));
endmodule

// File: rtl/selftest_tile.sv
module selftest_tile #(
  parameter int N     = 4,
  parameter int OUT_W = 2,
  parameter int BW    = (OUT_W > 1) ? $clog2(OUT_W) : 1,
  parameter logic [OUT_W*(2**N)-1:0] TABLE = {16'h8000, 16'h6996}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          selfcheck,
  input  logic          fault_en,
  input  logic [N-1:0]  fault_pat,
  input  logic [BW-1:0] fault_bit,
  input  logic          tck,
  input  logic          scan_en,
  input  logic          scan_in,
  output logic          scan_out,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  logic [N-1:0]     pattern;
  logic             compare_en;
  logic [OUT_W-1:0] resp_a;
  logic [OUT_W-1:0] resp_b;

  tile_pattern_gen #(.N(N)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
    .compare_en(compare_en), .busy(busy), .done(done)
  );

  tile_lut_model #(.N(N), .OUT_W(OUT_W), .BW(BW), .TABLE(TABLE)) u_but_a (
    .addr(pattern), .invert(1'b0), .flip_en(1'b0), .flip_pat('0),
    .flip_bit('0), .y(resp_a)
  );

  tile_lut_model #(.N(N), .OUT_W(OUT_W), .BW(BW), .TABLE(TABLE)) u_but_b (
    .addr(pattern), .invert(selfcheck), .flip_en(fault_en),
    .flip_pat(fault_pat), .flip_bit(fault_bit), .y(resp_b)
  );

  tile_comparator #(.OUT_W(OUT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(compare_en),
    .resp_a(resp_a), .resp_b(resp_b), .fail(fail)
  );

  tile_scan_cell u_scan (
    .tck(tck), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .capture_d(fail), .q(scan_out)
  );

  // R10: running and finished are exclusive
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R7: self-check makes every compared vector a mismatch
  assert_selfcheck_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (compare_en && selfcheck && !start) |=> fail);
endmodule

// File: tb/test_selftest_tile.sv
module test_selftest_tile;
  localparam int PER  = 10;
  localparam int N    = 4;
  localparam int PATS = 16;

  logic       clk = 0, rst_n = 0, start = 0, selfcheck = 0, fault_en = 0;
  logic [3:0] fault_pat = 0;
  logic [0:0] fault_bit = 0;
  logic       tck = 0, scan_en = 0, scan_in = 0;
  logic       scan_out, busy, done, fail;
  int total = 0, bad = 0;

  always #(PER/2) clk = ~clk;

  selftest_tile #(.N(N)) i_selftest_tile (
    .clk(clk), .rst_n(rst_n), .start(start), .selfcheck(selfcheck),
    .fault_en(fault_en), .fault_pat(fault_pat), .fault_bit(fault_bit),
    .tck(tck), .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .busy(busy), .done(done), .fail(fail)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R2 busy after start", busy, 1);
    chk("R2 done after start", done, 0);
    chk("R2 fail after start", fail, 0);
  endtask

  task automatic wait_end(output int cycles);
    cycles = 1;
    while (busy && cycles < 1000) begin
      @(negedge clk);
      if (busy) cycles++;
    end
  endtask

  task automatic run(input bit sc, input bit fe, input int fp, input int fb,
                     input bit exp_fail, input string req);
    int cyc;
    selfcheck = sc; fault_en = fe; fault_pat = fp[3:0]; fault_bit = fb[0:0];
    do_start();
    wait_end(cyc);
    chk({req, " R3 run length"}, cyc, PATS);
    chk({req, " R3 done"}, done, 1);
    chk({req, " R10 not busy"}, busy, 0);
    chk({req, " verdict"}, fail, int'(exp_fail));
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 scan_out", scan_out, 0);
  endtask

  task automatic t_sticky();
    run(0, 1, 7, 0, 1, "R6 setup");
    fault_en = 0;
    repeat (6) @(negedge clk);
    chk("R6 fail held", fail, 1);
    chk("R10 done held", done, 1);
    do_start();
    chk("R6 cleared by start", fail, 0);
  endtask

  task automatic t_restart();
    int cyc;
    selfcheck = 0; fault_en = 0;
    do_start();
    repeat (5) @(negedge clk);
    chk("R9 mid run busy", busy, 1);
    do_start();
    wait_end(cyc);
    chk("R9 restart length", cyc, PATS);
    chk("R9 done", done, 1);
    chk("R9 verdict", fail, 0);
  endtask

  task automatic pulse_tck(input bit en, input bit din);
    @(negedge clk); scan_en = en; scan_in = din;
    #1 tck = 1; #(PER/2) tck = 0; #1;
  endtask

  task automatic t_scan();
    run(1, 0, 0, 0, 1, "R8 setup");
    pulse_tck(0, 0);
    chk("R8 capture fail", scan_out, 1);
    pulse_tck(1, 0);
    chk("R8 shift 0", scan_out, 0);
    pulse_tck(1, 1);
    chk("R8 shift 1", scan_out, 1);
    run(0, 0, 0, 0, 0, "R8 pass setup");
    pulse_tck(0, 1);
    chk("R8 capture pass", scan_out, 0);
  endtask

  initial begin
    #(PER*150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run(0, 0, 0, 0, 0, "R4 clean");
    run(0, 1, 0, 0, 1, "R5 vec0 bit0");
    run(0, 1, 15, 1, 1, "R5 vec15 bit1");
    run(0, 1, 9, 1, 1, "R5 vec9 bit1");
    run(1, 0, 0, 0, 1, "R7 selfcheck");
    run(0, 0, 0, 0, 0, "R4 after selfcheck");
    t_sticky();
    t_restart();
    t_scan();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule